// File: doc/BRIEF.md
# Three-Stage Decimating Filter Chain

This block turns a stream of oversampled converter words, one per clock, into a slower stream of filtered words. A fixed divide-by-four integrator-comb stage feeds a second integrator-comb stage whose ratio is picked from four settings. That stage feeds a 16-tap symmetric FIR that halves the rate once more. The FIR can be skipped. Each word that leaves the block carries a tag saying whether it went through the FIR (fully filtered) or skipped it (partially filtered).

The FIR coefficients come up at a unity-gain default and can be rewritten through a small write port. A restart clears every stage. A restart happens on reset, on a change of ratio or bypass, and on every coefficient write. After a restart the valid bit stays low until enough output words have gone by for the chain to settle. The settling count depends on the configuration and is measured in output strobes, so no real-time constants are involved.

Top module: `dec_chain_top`

## Requirements
- R1: While reset is high and in the cycle after it, `out_stb`, `out_valid`, `out_partial` and `out_data` are all zero.
- R2: Consecutive output strobes after a restart are exactly 4·(4 << `ratio_sel`)·(`bypass` ? 1 : 2) clocks apart. The `ratio_sel` codes 0, 1, 2, 3 select a second-stage ratio of 4, 8, 16, 32.
- R3: With the default coefficients, a constant input x gives `out_data` equal to x once valid, whether or not the FIR is bypassed.
- R4: `out_partial` is 1 on every strobe while `bypass` is 1, and 0 on every strobe while it is 0.
- R5: An input that alternates between +A and −A on each clock gives `out_data` equal to 0 once valid.
- R6: `out_valid` rises together with the K-th strobe after a restart, never earlier. K is 6 when bypassed and 14 when the FIR is active.
- R7: `out_stb` lasts one clock. `out_data` changes only together with a strobe or on a restart.
- R8: A change of `ratio_sel` or `bypass`, or any coefficient write, makes `out_valid` low in the next cycle and restarts the strobe count of R6.
- R9: A write sets coefficient k (`coef_addr` = k, 0..7, a signed 16-bit value with 15 fraction bits) for taps k and 15−k. The FIR output is floor((Σ taps·coef + 2^14) / 2^15), so the DC gain is 2·Σc_k / 32768 and ties round upward.
- R10: Any result outside the 24-bit signed range is clamped to 8388607 or −8388608.
- R11: Reset restores the default coefficient set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one input word per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 24 | Signed oversampled input word |
| ratio_sel | input | 2 | Second-stage ratio code (4 << code) |
| bypass | input | 1 | 1 skips the FIR stage |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient index, pair k and 15−k |
| coef_data | input | 16 | Signed coefficient, 15 fraction bits |
| out_data | output | 24 | Filtered word, held between strobes |
| out_stb | output | 1 | One-cycle pulse per output word |
| out_partial | output | 1 | 1 when the word skipped the FIR |
| out_valid | output | 1 | Chain has settled since the last restart |

## Verification
The bench builds the block with its default parameters: a 24-bit input, second-order integrator-comb stages, 16 taps and 16-bit coefficients with 15 fraction bits. At unity gain, a full-scale input can then be run without clipping, and a coefficient set with a gain of two pushes the result past the 24-bit range so that clamping can be observed. The slowest setting has a 256-clock output period and a settling count of 14, which is short enough to exercise every ratio code and both bypass settings. A single-nonzero-coefficient set makes the rounding tie visible one step either side of it.

// File: rtl/dec_chain_pkg.sv
package dec_chain_pkg;

  // Triangular weights (k+1), scaled so that the two symmetric halves sum to 2^frac.
  // The remainder of the integer division goes to the centre pair.
  function automatic int default_coef(input int k, input int half, input int frac);
    int tot;
    int base;
    int rem;
    tot  = half * (half + 1) / 2;
    base = (1 << (frac - 1)) / tot;
    rem  = (1 << (frac - 1)) - base * tot;
    return base * (k + 1) + ((k == half - 1) ? rem : 0);
  endfunction

  // Output strobes needed after a restart before the chain is settled.
  function automatic int settle_strobes(input int order, input int ntaps, input bit full);
    return 2 * order + 2 + (full ? ntaps / 2 : 0);
  endfunction

endpackage

// File: rtl/dec_cic.sv
module dec_cic #(
  parameter int IN_W     = 24,
  parameter int OUT_W    = 24,
  parameter int ORDER    = 2,
  parameter int MAX_LOG2 = 5,
  parameter int LOG_W    = 3
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  in_dat,
  input  logic [LOG_W-1:0]        ratio_log2,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_dat
);
  localparam int ACC_W = IN_W + ORDER * MAX_LOG2;
  localparam int SH_W  = $clog2(ORDER * MAX_LOG2 + 1);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] integ [ORDER];
  logic signed [ACC_W-1:0] dly   [ORDER];
  logic signed [ACC_W-1:0] cv    [ORDER+1];
  logic [MAX_LOG2-1:0]     cnt;
  logic [MAX_LOG2-1:0]     last_cnt;
  logic [SH_W-1:0]         sh;
  logic                    take;
  logic signed [ACC_W-1:0] half_lsb;
  logic signed [ACC_W-1:0] rnd;

  assign last_cnt = MAX_LOG2'((1 << ratio_log2) - 1);
  assign take     = in_vld && (cnt == last_cnt);
  assign sh       = SH_W'(ORDER) * SH_W'(ratio_log2);

  always_ff @(posedge clk) begin
    if (clr) cnt <= '0;
    else if (in_vld) cnt <= take ? '0 : cnt + 1'b1;
  end

  // integrator chain at input rate
  always_ff @(posedge clk) begin
    if (clr) integ[0] <= '0;
    else if (in_vld) integ[0] <= integ[0] + ACC_W'(in_dat);
  end

  for (genvar g = 1; g < ORDER; g++) begin : g_int
    always_ff @(posedge clk) begin
      if (clr) integ[g] <= '0;
      else if (in_vld) integ[g] <= integ[g] + integ[g-1];
    end
  end

  // comb chain at decimated rate
  assign cv[0] = integ[ORDER-1];
  for (genvar g = 0; g < ORDER; g++) begin : g_comb
    assign cv[g+1] = cv[g] - dly[g];
    always_ff @(posedge clk) begin
      if (clr) dly[g] <= '0;
      else if (take) dly[g] <= cv[g];
    end
  end

  // gain normalisation: R^ORDER is a power of two
  assign half_lsb = {{(ACC_W-1){1'b0}}, 1'b1} << (sh - SH_W'(1));
  assign rnd      = (cv[ORDER] + half_lsb) >>> sh;

  always_ff @(posedge clk) begin
    if (clr) begin
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= take;
      if (take) begin
        if (rnd > MAXV)      out_dat <= OUT_W'(MAXV);
        else if (rnd < MINV) out_dat <= OUT_W'(MINV);
        else                 out_dat <= OUT_W'(rnd);
      end
    end
  end
endmodule

// File: rtl/dec_coef_bank.sv
module dec_coef_bank #(
  parameter int HALF = 8,
  parameter int CW   = 16,
  parameter int FRAC = 15,
  parameter int AW   = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic signed [CW-1:0] wdata,
  output logic [HALF*CW-1:0]   coefs
);
  logic signed [CW-1:0] mem [HALF];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HALF; k++)
        mem[k] <= CW'(dec_chain_pkg::default_coef(k, HALF, FRAC));
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  for (genvar k = 0; k < HALF; k++) begin : g_flat
    assign coefs[k*CW +: CW] = mem[k];
  end
endmodule

// File: rtl/dec_fir_sym.sv
module dec_fir_sym #(
  parameter int DW    = 24,
  parameter int CW    = 16,
  parameter int NTAPS = 16,
  parameter int FRAC  = 15
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     in_vld,
  input  logic signed [DW-1:0]     in_dat,
  input  logic [NTAPS/2*CW-1:0]    coefs,
  output logic                     out_vld,
  output logic signed [DW-1:0]     out_dat
);
  localparam int HALF  = NTAPS / 2;
  localparam int IDX_W = $clog2(HALF);
  localparam int TAP_W = $clog2(NTAPS);
  localparam int SUMW  = DW + 1;
  localparam int PW    = SUMW + CW;
  localparam int ACCW  = PW + IDX_W + 1;
  localparam logic signed [ACCW-1:0] MAXV  = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] MINV  = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};
  localparam logic signed [ACCW-1:0] RHALF = {{(ACCW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [DW-1:0]   tap [NTAPS];
  logic                   phase;
  logic                   busy;
  logic                   done;
  logic [IDX_W-1:0]       idx;
  logic [TAP_W-1:0]       mir;
  logic signed [SUMW-1:0] pair;
  logic signed [CW-1:0]   cf;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] rnd;

  // one shared multiplier, folded over the symmetric pair
  assign mir  = TAP_W'(NTAPS - 1) - TAP_W'(idx);
  assign pair = SUMW'(tap[TAP_W'(idx)]) + SUMW'(tap[mir]);
  assign cf   = coefs[idx*CW +: CW];
  assign prod = pair * cf;
  assign rnd  = (acc + RHALF) >>> FRAC;

  always_ff @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < NTAPS; i++) tap[i] <= '0;
      phase   <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      acc     <= '0;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= 1'b0;
      done    <= 1'b0;
      if (busy) begin
        acc <= acc + ACCW'(prod);
        idx <= idx + 1'b1;
        if (idx == IDX_W'(HALF - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (in_vld) begin
        tap[0] <= in_dat;
        for (int i = 1; i < NTAPS; i++) tap[i] <= tap[i-1];
        phase <= ~phase;
        if (phase) begin
          busy <= 1'b1;
          idx  <= '0;
          acc  <= '0;
        end
      end
      if (done) begin
        out_vld <= 1'b1;
        if (rnd > MAXV)      out_dat <= DW'(MAXV);
        else if (rnd < MINV) out_dat <= DW'(MINV);
        else                 out_dat <= DW'(rnd);
      end
    end
  end
endmodule

// File: rtl/dec_chain_top.sv
module dec_chain_top #(
  parameter int IN_W  = 24,
  parameter int OUT_W = 24,
  parameter int ORDER = 2,
  parameter int NTAPS = 16,
  parameter int CW    = 16,
  parameter int FRAC  = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [IN_W-1:0]    in_data,
  input  logic [1:0]                ratio_sel,
  input  logic                      bypass,
  input  logic                      coef_we,
  input  logic [$clog2(NTAPS/2)-1:0] coef_addr,
  input  logic signed [CW-1:0]      coef_data,
  output logic signed [OUT_W-1:0]   out_data,
  output logic                      out_stb,
  output logic                      out_partial,
  output logic                      out_valid
);
  localparam int HALF      = NTAPS / 2;
  localparam int AW        = $clog2(HALF);
  localparam int S1_LOG    = 2;
  localparam int S2_MAXLOG = 5;
  localparam int K_BYP     = dec_chain_pkg::settle_strobes(ORDER, NTAPS, 1'b0);
  localparam int K_FULL    = dec_chain_pkg::settle_strobes(ORDER, NTAPS, 1'b1);
  localparam int CNT_W     = $clog2(K_FULL + 1);

  logic [1:0]             sel_q;
  logic                   byp_q;
  logic                   clr;
  logic                   s1_vld, s2_vld, f3_vld, pick_vld;
  logic signed [OUT_W-1:0] s1_dat, s2_dat, f3_dat, pick_dat;
  logic [HALF*CW-1:0]     coef_flat;
  logic [CNT_W-1:0]       settle_cnt;
  logic [CNT_W-1:0]       settle_nx;
  logic [CNT_W-1:0]       settle_k;

  // any configuration event restarts the whole chain
  assign clr = rst || (ratio_sel != sel_q) || (bypass != byp_q) || coef_we;

  always_ff @(posedge clk) begin
    if (clr) begin
      sel_q <= ratio_sel;
      byp_q <= bypass;
    end
  end

  dec_coef_bank #(.HALF(HALF), .CW(CW), .FRAC(FRAC), .AW(AW)) u_coef (
    .clk(clk), .rst(rst), .we(coef_we), .addr(coef_addr),
    .wdata(coef_data), .coefs(coef_flat)
  );

  dec_cic #(.IN_W(IN_W), .OUT_W(OUT_W), .ORDER(ORDER), .MAX_LOG2(S1_LOG),
            .LOG_W($clog2(S1_LOG + 1))) u_s1 (
    .clk(clk), .clr(clr), .in_vld(1'b1), .in_dat(in_data),
    .ratio_log2(($clog2(S1_LOG + 1))'(S1_LOG)),
    .out_vld(s1_vld), .out_dat(s1_dat)
  );

  dec_cic #(.IN_W(OUT_W), .OUT_W(OUT_W), .ORDER(ORDER), .MAX_LOG2(S2_MAXLOG),
            .LOG_W(3)) u_s2 (
    .clk(clk), .clr(clr), .in_vld(s1_vld), .in_dat(s1_dat),
    .ratio_log2({1'b0, sel_q} + 3'd2),
    .out_vld(s2_vld), .out_dat(s2_dat)
  );

  dec_fir_sym #(.DW(OUT_W), .CW(CW), .NTAPS(NTAPS), .FRAC(FRAC)) u_s3 (
    .clk(clk), .clr(clr), .in_vld(s2_vld && !byp_q), .in_dat(s2_dat),
    .coefs(coef_flat), .out_vld(f3_vld), .out_dat(f3_dat)
  );

  assign pick_vld  = byp_q ? s2_vld : f3_vld;
  assign pick_dat  = byp_q ? s2_dat : f3_dat;
  assign settle_k  = byp_q ? CNT_W'(K_BYP) : CNT_W'(K_FULL);
  assign settle_nx = (settle_cnt >= settle_k) ? settle_cnt : settle_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (clr) begin
      out_data    <= '0;
      out_stb     <= 1'b0;
      out_partial <= 1'b0;
      out_valid   <= 1'b0;
      settle_cnt  <= '0;
    end else begin
      out_stb <= pick_vld;
      if (pick_vld) begin
        out_data    <= pick_dat;
        out_partial <= byp_q;
        settle_cnt  <= settle_nx;
        out_valid   <= (settle_nx >= settle_k);
      end
    end
  end
endmodule

// File: rtl/dec_chain_checker.sv
module dec_chain_checker #(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             clr,
  input logic [1:0]       sel_q,
  input logic             byp_q,
  input logic             out_stb,
  input logic             out_partial,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  logic [11:0] gap;
  logic        seen;
  logic [11:0] per;

  assign per = 12'((16 << sel_q) * (byp_q ? 1 : 2));

  always_ff @(posedge clk) begin
    if (clr) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (out_stb) begin
      gap  <= 12'd1;
      seen <= 1'b1;
    end else if (gap != 12'hfff) begin
      gap <= gap + 1'b1;
    end
  end

  assert_strobe_period_R2: assert property (@(posedge clk) disable iff (rst)
    (out_stb && seen) |-> (gap == per));

  assert_partial_tag_R4: assert property (@(posedge clk) disable iff (rst)
    out_stb |-> (out_partial == $past(byp_q)));

  assert_valid_with_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> out_stb);

  assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    out_stb |=> !out_stb);

  assert_data_held_R7: assert property (@(posedge clk) disable iff (rst)
    (!out_stb && !$past(clr)) |-> $stable(out_data));

  assert_restart_drop_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!out_valid && !out_stb));
endmodule

bind dec_chain_top dec_chain_checker #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .sel_q(sel_q), .byp_q(byp_q),
  .out_stb(out_stb), .out_partial(out_partial), .out_valid(out_valid),
  .out_data(out_data)
);

// File: tb/dec_chain_top_test.sv
module dec_chain_top_test;
  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic signed [23:0] in_data = '0;
  logic [1:0]         ratio_sel = '0;
  logic               bypass = 1'b0;
  logic               coef_we = 1'b0;
  logic [2:0]         coef_addr = '0;
  logic signed [15:0] coef_data = '0;
  logic signed [23:0] out_data;
  logic               out_stb, out_partial, out_valid;

  int n_chk = 0;
  int n_bad = 0;
  bit alt_mode = 1'b0;

  dec_chain_top uut (
    .clk(clk), .rst(rst), .in_data(in_data), .ratio_sel(ratio_sel),
    .bypass(bypass), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_data(out_data), .out_stb(out_stb),
    .out_partial(out_partial), .out_valid(out_valid)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (alt_mode) in_data = -in_data;
  endtask

  task automatic wait_strobe(output int gap);
    gap = 0;
    do begin
      step();
      gap++;
    end while (!out_stb && gap < 3000);
    if (gap >= 3000) chk(1'b0, "R2", "strobe timeout", gap, 0);
  endtask

  function automatic longint fir_expect(input longint x, input longint sumc);
    longint v;
    v = (x * 2 * sumc + 16384) >>> 15;
    if (v > 8388607) v = 8388607;
    if (v < -8388608) v = -8388608;
    return v;
  endfunction

  // Counts strobes from a restart that has just happened.
  task automatic measure(input int sel, input bit byp, input longint expv, input string tag);
    int k;
    int per;
    int gap;
    k   = byp ? 6 : 14;
    per = 4 * (4 << sel) * (byp ? 1 : 2);
    for (int n = 1; n <= k + 1; n++) begin
      wait_strobe(gap);
      if (n == k - 1) chk(out_valid == 1'b0, "R6", "valid before settle", out_valid, 0);
      if (n == k) begin
        chk(out_valid == 1'b1, "R6", "valid at settle strobe", out_valid, 1);
        chk(out_data == expv, tag, "data at settle", out_data, expv);
        chk(out_partial == byp, "R4", "partial tag", out_partial, byp);
      end
      if (n == k + 1) begin
        chk(gap == per, "R2", "strobe period", gap, per);
        chk(out_data == expv, tag, "data after settle", out_data, expv);
      end
    end
    step();
    chk(out_stb == 1'b0, "R7", "strobe width", out_stb, 0);
  endtask

  task automatic pulse_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  task automatic write_coef(input int a, input int v);
    coef_we   = 1'b1;
    coef_addr = 3'(a);
    coef_data = 16'(v);
    step();
    coef_we = 1'b0;
  endtask

  task automatic t_reset();
    step();
    step();
    chk(out_stb == 1'b0, "R1", "stb in reset", out_stb, 0);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    chk(out_partial == 1'b0, "R1", "partial in reset", out_partial, 0);
    chk(out_data == 0, "R1", "data in reset", out_data, 0);
    rst = 1'b0;
    step();
    chk(out_stb == 1'b0 && out_valid == 1'b0, "R1", "after reset", out_valid, 0);
  endtask

  task automatic t_dc(input int sel, input bit byp, input longint x, input string tag);
    alt_mode  = 1'b0;
    in_data   = 24'(x);
    ratio_sel = 2'(sel);
    bypass    = byp;
    pulse_reset();
    measure(sel, byp, x, tag);
  endtask

  task automatic t_alt(input int sel, input bit byp, input longint a);
    in_data   = 24'(a);
    alt_mode  = 1'b1;
    ratio_sel = 2'(sel);
    bypass    = byp;
    pulse_reset();
    measure(sel, byp, 0, "R5");
    alt_mode = 1'b0;
  endtask

  task automatic t_restart();
    t_dc(0, 1'b0, 777, "R3");
    bypass = 1'b1;
    step();
    chk(out_valid == 1'b0, "R8", "valid after bypass change", out_valid, 0);
    measure(0, 1'b1, 777, "R8");
    ratio_sel = 2'd2;
    step();
    chk(out_valid == 1'b0, "R8", "valid after ratio change", out_valid, 0);
    measure(2, 1'b1, 777, "R8");
  endtask

  task automatic t_coef_gain();
    bypass    = 1'b0;
    ratio_sel = 2'd0;
    in_data   = 24'sd3000;
    pulse_reset();
    measure(0, 1'b0, 3000, "R3");
    write_coef(0, 4096);
    chk(out_valid == 1'b0, "R8", "valid after coef write", out_valid, 0);
    for (int i = 1; i < 8; i++) write_coef(i, 4096);
    measure(0, 1'b0, fir_expect(3000, 32768), "R9");
  endtask

  task automatic t_round();
    for (int i = 0; i < 8; i++) write_coef(i, (i == 0) ? 1 : 0);
    in_data = 24'sd8192;
    write_coef(1, 0);
    measure(0, 1'b0, fir_expect(8192, 1), "R9");
    in_data = 24'sd8191;
    write_coef(1, 0);
    measure(0, 1'b0, fir_expect(8191, 1), "R9");
  endtask

  task automatic t_sat();
    for (int i = 0; i < 8; i++) write_coef(i, 4096);
    in_data = 24'sd5000000;
    write_coef(0, 4096);
    measure(0, 1'b0, 8388607, "R10");
    in_data = -24'sd5000000;
    write_coef(0, 4096);
    measure(0, 1'b0, -8388608, "R10");
  endtask

  initial begin
    t_reset();
    t_dc(0, 1'b0, 1000, "R3");
    t_dc(3, 1'b1, -5000, "R3");
    t_dc(1, 1'b0, 8388607, "R3");
    t_dc(2, 1'b1, -8388608, "R3");
    t_alt(2, 1'b0, 3000000);
    t_alt(1, 1'b1, -2000000);
    t_restart();
    t_coef_gain();
    t_round();
    t_sat();
    t_dc(1, 1'b0, -123456, "R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule